// File: doc/BRIEF.md
# Overlapped Translation and Physically Tagged Cache Lookup

This block is the read-lookup path of a small direct-mapped data cache. The cache is indexed with virtual address bits that translation leaves unchanged, while a translation lookaside buffer maps the page number at the same time. Because the index bits sit inside the 4 KB page displacement, the cache line can be read during the same cycle as the TLB lookup. The stored tag is then compared against the physical page number that the TLB returns, so the cache holds physical tags. Two virtual pages that map to one physical page therefore share a single line.

A CPU presents a 32-bit virtual address with a valid/ready handshake, and only one request may be outstanding. There are three possible outcomes. If the TLB hits and the selected line is valid with a tag equal to the physical page number, the word is returned. If the TLB hits but the line does not match, the block issues a main-memory read with the physical address. When the fill returns, the line is written and the lookup is replayed. If the TLB misses, the block asks for a translation walk and replays the lookup once the walk completes.

The default geometry is 1024 lines of 4 bytes each. That uses 10 index bits and 2 byte-offset bits, which together fit in the 12-bit displacement. Elaboration stops on any parameter set whose index and offset bits would reach into the page number. An example is an 8 KB direct-mapped cache on 4 KB pages, whose index would need address bit 12.

Top module: `vipt_lookup`

## Requirements
- R1: Reset clears every line's valid bit and leaves the block idle: req_ready high, rsp_valid, mem_req_valid and walk_req_valid low. The first access to any line after reset goes to memory.
- R2: In the lookup cycle, which is the cycle after a request is accepted, tlb_vpn carries virtual address bits 31:12. The line is selected by bits 11:2, so two addresses that differ only in bits 1:0 use the same line.
- R3: When the TLB hits and the selected line is valid with a tag equal to tlb_ppn, rsp_valid is high in the lookup cycle with the line's word. No memory or walk request is made.
- R4: When the TLB hits but the line is invalid or its tag differs, no response is given. From the next cycle, mem_req_valid stays high with mem_req_paddr = {tlb_ppn, vaddr[11:0]} unchanged until mem_fill_valid.
- R5: When the TLB misses, no response and no memory request are made. From the next cycle, walk_req_valid stays high with walk_req_vpn = vaddr[31:12] until walk_done, after which the lookup is repeated.
- R6: In the cycle with mem_fill_valid, the line is written with the fill word, the physical page number as its tag, and valid set. The next cycle repeats the lookup and responds with the filled word.
- R7: At most one request is outstanding. req_ready is high only while idle, and it falls in the cycle after a request is accepted.
- R8: Lines are tagged physically. An access through a different virtual page that maps to the same physical page hits a line filled through the first page. An access to the same index with a different physical page misses and replaces that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual byte address of the request |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_data | output | 32 | Word read from the cache |
| tlb_vpn | output | 20 | Virtual page number presented to the TLB |
| tlb_hit | input | 1 | TLB holds a translation for tlb_vpn |
| tlb_ppn | input | 20 | Physical page number from the TLB |
| mem_req_valid | output | 1 | Main-memory line read requested |
| mem_req_paddr | output | 32 | Physical byte address for the memory read |
| mem_fill_valid | input | 1 | Memory read data is present |
| mem_fill_data | input | 32 | Line word returned by memory |
| walk_req_valid | output | 1 | Translation walk requested |
| walk_req_vpn | output | 20 | Virtual page number to translate |
| walk_done | input | 1 | Translation walk finished |

## Verification
The assertions take three things for granted about the inputs. First, the TLB answers in the same cycle as tlb_vpn. Second, for a given page, the TLB keeps the same hit and physical page number while a request is outstanding, except that a completed walk may turn a miss into a hit. Third, mem_fill_valid and walk_done arrive only while the matching request is raised. The bench stays inside these limits. Its TLB is a fixed function of the page number plus a set of resident pages that only grows. It raises fills and walk completions only after seeing the matching request, and only after a random wait.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  // Default geometry: 4 KB pages, 1024 lines of one 32-bit word.
  localparam int DEF_VA_W       = 32;
  localparam int DEF_PA_W       = 32;
  localparam int DEF_PAGE_W     = 12;
  localparam int DEF_LINE_BYTES = 4;
  localparam int DEF_LINES      = 1024;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for a CPU request
    ST_LOOK = 2'd1,  // TLB and line read in parallel
    ST_FILL = 2'd2,  // memory read outstanding
    ST_WALK = 2'd3   // translation walk outstanding
  } lookup_state_e;

endpackage

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 20,
  parameter int DATA_W  = 32,
  localparam int LINES  = 1 << INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0]  wr_data
);

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  // Valid bits are the only state cleared by reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];

  // R6: a written line is valid afterwards.
  assert_fill_sets_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/vipt_tag_match.sv
module vipt_tag_match #(
  parameter int TAG_W = 20
) (
  input  logic             tlb_hit,
  input  logic [TAG_W-1:0] tlb_ppn,
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  output logic             line_hit,
  output logic             need_fill,
  output logic             need_walk
);

  logic [TAG_W-1:0] bit_same;
  logic             tag_equal;

  for (genvar b = 0; b < TAG_W; b++) begin : g_bit_cmp
    assign bit_same[b] = ~(tlb_ppn[b] ^ line_tag[b]);
  end

  assign tag_equal = &bit_same;

  // Priority: a hit needs the translation; without it, walk first.
  assign line_hit  = tlb_hit & line_valid & tag_equal;
  assign need_fill = tlb_hit & ~(line_valid & tag_equal);
  assign need_walk = ~tlb_hit;

endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          line_hit,
  input  logic          need_fill,
  input  logic          need_walk,
  input  logic          mem_fill_valid,
  input  logic          walk_done,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic          mem_req_valid,
  output logic          walk_req_valid,
  output logic          capture_req,
  output logic          capture_pa,
  output logic          fill_write,
  output lookup_state_e state
);

  lookup_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_LOOK;
      ST_LOOK: begin
        if (line_hit)       state_d = ST_IDLE;
        else if (need_walk) state_d = ST_WALK;
        else if (need_fill) state_d = ST_FILL;
      end
      ST_FILL: if (mem_fill_valid) state_d = ST_LOOK;
      ST_WALK: if (walk_done)      state_d = ST_LOOK;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state          = state_q;
  assign req_ready      = (state_q == ST_IDLE);
  assign capture_req    = (state_q == ST_IDLE) & req_valid;
  assign rsp_valid      = (state_q == ST_LOOK) & line_hit;
  assign capture_pa     = (state_q == ST_LOOK) & need_fill;
  assign mem_req_valid  = (state_q == ST_FILL);
  assign walk_req_valid = (state_q == ST_WALK);
  assign fill_write     = (state_q == ST_FILL) & mem_fill_valid;

  // R7: one request in flight.
  assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4: memory request held until its fill.
  assert_mem_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_fill_valid) |=> mem_req_valid);

  // R5: walk request held until done.
  assert_walk_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_done) |=> walk_req_valid);

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int  VA_W       = DEF_VA_W,
  parameter int  PA_W       = DEF_PA_W,
  parameter int  PAGE_W     = DEF_PAGE_W,
  parameter int  LINE_BYTES = DEF_LINE_BYTES,
  parameter int  LINES      = DEF_LINES,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int INDEX_W    = $clog2(LINES),
  localparam int VPN_W      = VA_W - PAGE_W,
  localparam int PPN_W      = PA_W - PAGE_W,
  localparam int DATA_W     = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [VPN_W-1:0]  tlb_vpn,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_paddr,
  input  logic              mem_fill_valid,
  input  logic [DATA_W-1:0] mem_fill_data,
  output logic              walk_req_valid,
  output logic [VPN_W-1:0]  walk_req_vpn,
  input  logic              walk_done
);

  // The line index must come from untranslated bits only.
  if (OFF_W + INDEX_W > PAGE_W) begin : g_overlap_check
    $error("vipt_lookup: index and offset bits exceed the page displacement");
  end

  function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_W];
  endfunction

  function automatic logic [PAGE_W-1:0] disp_of(input logic [VA_W-1:0] va);
    return va[PAGE_W-1:0];
  endfunction

  function automatic logic [INDEX_W-1:0] index_of(input logic [VA_W-1:0] va);
    return va[OFF_W +: INDEX_W];
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(input logic [PPN_W-1:0] ppn,
                                                input logic [PAGE_W-1:0] disp);
    return {ppn, disp};
  endfunction

  logic [VA_W-1:0]    vaddr_q;
  logic [PA_W-1:0]    paddr_q;
  logic               capture_req, capture_pa, fill_write;
  logic               lookup_hit, lookup_fill, lookup_walk;
  logic               line_valid;
  logic [PPN_W-1:0]   line_tag;
  logic [DATA_W-1:0]  line_data;
  logic [INDEX_W-1:0] line_idx;
  lookup_state_e      state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      paddr_q <= '0;
    end else begin
      if (capture_req) vaddr_q <= req_vaddr;
      if (capture_pa)  paddr_q <= phys_addr(tlb_ppn, disp_of(vaddr_q));
    end
  end

  assign line_idx = index_of(vaddr_q);

  vipt_line_store #(
    .INDEX_W (INDEX_W),
    .TAG_W   (PPN_W),
    .DATA_W  (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (line_idx),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .rd_data  (line_data),
    .wr_en    (fill_write),
    .wr_idx   (line_idx),
    .wr_tag   (paddr_q[PA_W-1:PAGE_W]),
    .wr_data  (mem_fill_data)
  );

  vipt_tag_match #(
    .TAG_W (PPN_W)
  ) u_match (
    .tlb_hit    (tlb_hit),
    .tlb_ppn    (tlb_ppn),
    .line_valid (line_valid),
    .line_tag   (line_tag),
    .line_hit   (lookup_hit),
    .need_fill  (lookup_fill),
    .need_walk  (lookup_walk)
  );

  vipt_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .line_hit       (lookup_hit),
    .need_fill      (lookup_fill),
    .need_walk      (lookup_walk),
    .mem_fill_valid (mem_fill_valid),
    .walk_done      (walk_done),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .mem_req_valid  (mem_req_valid),
    .walk_req_valid (walk_req_valid),
    .capture_req    (capture_req),
    .capture_pa     (capture_pa),
    .fill_write     (fill_write),
    .state          (state)
  );

  assign tlb_vpn       = vpn_of(vaddr_q);
  assign walk_req_vpn  = vpn_of(vaddr_q);
  assign mem_req_paddr = paddr_q;
  assign rsp_data      = line_data;

  // R2: the TLB sees the accepted page number in the lookup cycle.
  assert_vpn_to_tlb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (tlb_vpn == $past(req_vaddr[VA_W-1:PAGE_W])));

  // R4: the physical address holds while memory is busy.
  assert_paddr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_fill_valid) |=> $stable(mem_req_paddr));

  // R6: a fill is followed by a replayed hit with the fill word.
  assert_fill_replay_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_fill_valid) |=> (rsp_valid && rsp_data == $past(mem_fill_data)));

  // R3: a response never coexists with a pending miss action.
  assert_rsp_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (tlb_hit && !mem_req_valid && !walk_req_valid));

endmodule

// File: tb/vipt_lookup_test.sv
`timescale 1ns/1ps
module vipt_lookup_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [19:0] tlb_vpn;
  logic        tlb_hit;
  logic [19:0] tlb_ppn;
  logic        mem_req_valid;
  logic [31:0] mem_req_paddr;
  logic        mem_fill_valid = 1'b0;
  logic [31:0] mem_fill_data = '0;
  logic        walk_req_valid;
  logic [19:0] walk_req_vpn;
  logic        walk_done = 1'b0;

  int errors = 0;
  int checks = 0;

  // Bench TLB: pages with low nibble F are absent until walked.
  logic [1023:0] walked = '0;
  // Bench view of the cache contents.
  logic [1023:0] valid_m = '0;
  logic [19:0]   tag_m [1024];

  always #5 clk = ~clk;

  function automatic logic [19:0] ppn_of(input logic [19:0] vpn);
    return {8'hA5, 6'h00, vpn[5:0]};
  endfunction

  function automatic bit resident(input logic [19:0] vpn);
    return (vpn[3:0] != 4'hF) || walked[vpn[9:0]];
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] pa);
    return pa * 32'h9E3779B1 + 32'h0BADF00D;
  endfunction

  assign tlb_hit = (tlb_vpn[3:0] != 4'hF) || walked[tlb_vpn[9:0]];
  assign tlb_ppn = ppn_of(tlb_vpn);

  vipt_lookup uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .rsp_valid      (rsp_valid),
    .rsp_data       (rsp_data),
    .tlb_vpn        (tlb_vpn),
    .tlb_hit        (tlb_hit),
    .tlb_ppn        (tlb_ppn),
    .mem_req_valid  (mem_req_valid),
    .mem_req_paddr  (mem_req_paddr),
    .mem_fill_valid (mem_fill_valid),
    .mem_fill_data  (mem_fill_data),
    .walk_req_valid (walk_req_valid),
    .walk_req_vpn   (walk_req_vpn),
    .walk_done      (walk_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_outputs(input string req);
    chk(req_ready === 1'b1, req, "req_ready idle", req_ready, 1);
    chk(rsp_valid === 1'b0, req, "rsp_valid idle", rsp_valid, 0);
    chk(mem_req_valid === 1'b0, req, "mem_req_valid idle", mem_req_valid, 0);
    chk(walk_req_valid === 1'b0, req, "walk_req_valid idle", walk_req_valid, 0);
  endtask

  // One complete read; inputs driven and outputs sampled at negedges.
  task automatic access(input logic [31:0] va, input string first_req);
    logic [19:0] vpn;
    logic [9:0]  idx;
    logic [19:0] ppn;
    logic [31:0] exp;
    bit replay;
    bit done;
    vpn = va[31:12];
    idx = va[11:2];
    ppn = ppn_of(vpn);
    replay = 0;
    done = 0;
    chk(req_ready === 1'b1, "R7", "ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = $urandom;
    chk(req_ready === 1'b0, "R7", "ready drops after accept", req_ready, 0);
    for (int step = 0; step < 6 && !done; step++) begin
      chk(tlb_vpn === vpn, "R2", "page number to TLB", tlb_vpn, vpn);
      if (!resident(vpn)) begin
        chk(rsp_valid === 1'b0, "R5", "no response on TLB miss", rsp_valid, 0);
        @(negedge clk);
        chk(walk_req_valid === 1'b1 && walk_req_vpn === vpn, "R5", "walk request",
            {walk_req_valid, walk_req_vpn}, {1'b1, vpn});
        chk(mem_req_valid === 1'b0, "R5", "no memory read on TLB miss", mem_req_valid, 0);
        for (int w = 0; w < 1 + int'($urandom % 3); w++) begin
          chk(req_ready === 1'b0 && walk_req_valid === 1'b1, "R7", "busy during walk",
              {req_ready, walk_req_valid}, 2'b01);
          @(negedge clk);
        end
        walked[vpn[9:0]] = 1'b1;
        walk_done = 1'b1;
        @(negedge clk);
        walk_done = 1'b0;
      end else if (valid_m[idx] && tag_m[idx] == ppn) begin
        exp = mem_word({ppn, idx, 2'b00});
        chk(rsp_valid === 1'b1 && rsp_data === exp, replay ? "R6" : first_req,
            "hit data", {rsp_valid, rsp_data}, {1'b1, exp});
        chk(mem_req_valid === 1'b0 && walk_req_valid === 1'b0, "R3", "no miss action on hit",
            {mem_req_valid, walk_req_valid}, 0);
        done = 1;
        @(negedge clk);
      end else begin
        chk(rsp_valid === 1'b0, "R4", "no response on line miss", rsp_valid, 0);
        @(negedge clk);
        chk(mem_req_valid === 1'b1 && mem_req_paddr === {ppn, va[11:0]}, "R4",
            "memory request", {mem_req_valid, mem_req_paddr}, {1'b1, ppn, va[11:0]});
        for (int w = 0; w < int'($urandom % 3); w++) begin
          @(negedge clk);
          chk(mem_req_valid === 1'b1 && mem_req_paddr === {ppn, va[11:0]}, "R4",
              "memory request held", {mem_req_valid, mem_req_paddr}, {1'b1, ppn, va[11:0]});
        end
        mem_fill_valid = 1'b1;
        mem_fill_data = mem_word({ppn, idx, 2'b00});
        valid_m[idx] = 1'b1;
        tag_m[idx] = ppn;
        @(negedge clk);
        mem_fill_valid = 1'b0;
        mem_fill_data = $urandom;
        replay = 1;
      end
    end
    chk(done, "R6", "access completed", done, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    valid_m = '0;
    repeat (2) @(negedge clk);
    idle_outputs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    idle_outputs("R1");
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [19:0] rv;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // R1: cold line misses, R4/R6 fill and replay, then R3 plain hit.
    access({20'h00012, 10'd5, 2'd0}, "R1");
    access({20'h00012, 10'd5, 2'd0}, "R3");
    // R2: other byte of the same word shares the line; another index is separate.
    access({20'h00012, 10'd5, 2'd3}, "R2");
    access({20'h00012, 10'd6, 2'd1}, "R2");
    // R8: synonym page (bit 10 differs, same physical page) hits at once.
    access({20'h00412, 10'd5, 2'd2}, "R8");
    // R8: same index, other physical page evicts; the original misses again.
    access({20'h00013, 10'd5, 2'd0}, "R8");
    access({20'h00012, 10'd5, 2'd0}, "R8");
    // R5: absent translation walks, then fills, then hits.
    access({20'h0002F, 10'd9, 2'd0}, "R5");
    access({20'h0002F, 10'd9, 2'd0}, "R5");
    // R1: reset in mid-run invalidates filled lines.
    do_reset();
    access({20'h00012, 10'd6, 2'd1}, "R1");

    for (int n = 0; n < 250; n++) begin
      rv = {8'h00, 6'($urandom % 4), 6'($urandom % 64)};
      access({rv, 10'($urandom % 8), 2'($urandom % 4)}, "R3");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule